// File: doc/BRIEF.md
# Posted-Write Parity Error Handler

This block watches the data parity of posted writes crossing one direction of a two-sided PCI-style bridge. On the side the write comes from (the initiator side), it checks even parity over each data phase. When the check fails it pulses an active-low parity-error output if the initiator-side response enable is set, and it records the error in a sticky status bit. The write is still forwarded unchanged, but its outgoing parity bit is inverted, so the target sees the same bad parity the bridge saw.

On the side the write goes to (the target side), the block samples the target's active-low parity-error report a fixed number of clocks after each forwarded data phase. A tag pipeline records, for each forwarded phase, whether the bridge itself had already found and passed on the error. From that tag and a set of static enables, the block decides whether to record a target-side detected-parity status. It also decides whether to raise a one-clock system-error pulse toward the initiator side and to record that the pulse was signalled.

The upstream direction uses a second instance with the two sides swapped. Routing, buffering and configuration decoding live outside the block, and the control bits arrive as static inputs.

Top module: `pwpe_handler`

## Requirements
- R1: When the parity sampled on `ini_par` at the edge after an `ini_xfer` phase differs from the even parity of that phase's `ini_ad` and `ini_cbe_n`, `ini_perr_n` is driven low for exactly one clock. It becomes low right after that parity-sampling edge, so the initiator samples it two edges after the data phase. This happens only when `ini_per_en` is 1.
- R2: Every such initiator-side parity error sets `sts_ini_ped` at that parity-sampling edge, whatever the value of `ini_per_en`.
- R3: Even parity means `par = ^{ad, cbe_n}`. One clock after `tgt_xfer` is high, `tgt_par` carries the even parity of the forwarded `tgt_ad`/`tgt_cbe_n`, inverted when that phase had an initiator-side parity error.
- R4: Each `ini_xfer` phase appears on `tgt_xfer`, `tgt_ad` and `tgt_cbe_n` one clock later with the data and byte enables unchanged, whether or not it carries a parity error. No phase is dropped or stalled. After reset, `tgt_xfer` is 0 and both error outputs are 1.
- R5: `tgt_perr_n` is sampled `TGT_PERR_LAT` edges after the edge at which the target sampled a forwarded phase. A low value then sets `sts_tgt_dpd` only when `tgt_per_en` is 1.
- R6: A matched target report drives `ini_serr_n` low for one clock and sets `sts_sse` at the same edge, but only when `serr_en` = 1, `pw_serr_dis` = 0, `tgt_per_en` = 1 and `ini_per_en` = 1. If any of these four conditions fails, neither happens.
- R7: A target report for a phase whose error the bridge detected on the initiator side and forwarded never raises `ini_serr_n` or sets `sts_sse`. It still sets `sts_tgt_dpd` under R5.
- R8: A low `tgt_perr_n` at a sampling edge with no forwarded phase due at that edge is ignored: no status changes and no system-error pulse.
- R9: Each status bit is sticky and clears at an edge where its strobe (`clr_ini_ped`, `clr_tgt_dpd`, `clr_sse`) is 1. A set condition at the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ini_per_en | input | 1 | Initiator-side parity response enable |
| tgt_per_en | input | 1 | Target-side parity response enable |
| serr_en | input | 1 | System-error reporting enable |
| pw_serr_dis | input | 1 | Suppresses system error for posted-write parity events |
| ini_xfer | input | 1 | Data phase completes on the initiator side this clock |
| ini_ad | input | DATA_W | Initiator-side address/data word |
| ini_cbe_n | input | DATA_W/8 | Initiator-side byte enables (active low) |
| ini_par | input | 1 | Initiator-side parity, one clock after its phase |
| ini_perr_n | output | 1 | Initiator-side parity-error pulse (active low) |
| tgt_xfer | output | 1 | Forwarded data phase on the target side |
| tgt_ad | output | DATA_W | Forwarded address/data word |
| tgt_cbe_n | output | DATA_W/8 | Forwarded byte enables |
| tgt_par | output | 1 | Forwarded parity, one clock after its phase |
| tgt_perr_n | input | 1 | Parity-error report from the target (active low) |
| ini_serr_n | output | 1 | System-error pulse toward the initiator side (active low) |
| sts_ini_ped | output | 1 | Sticky: parity error detected on initiator side |
| sts_tgt_dpd | output | 1 | Sticky: data parity reported by target |
| sts_sse | output | 1 | Sticky: system error signalled |
| clr_ini_ped | input | 1 | Write-one-to-clear strobe for `sts_ini_ped` |
| clr_tgt_dpd | input | 1 | Write-one-to-clear strobe for `sts_tgt_dpd` |
| clr_sse | input | 1 | Write-one-to-clear strobe for `sts_sse` |

## Verification
The bench builds the block with a 32-bit word, which gives four byte-lane parity groups, and a target report latency of three edges. Its emulated target answers exactly three edges after it samples a phase, so reports land on the tag slot the block is watching. Back-to-back phases therefore put three tags in flight at once. This lets a forwarded-bad phase sit next to a clean but target-corrupted phase, which separates the R7 suppression from the R6 pulse.

// File: rtl/pwpe_pkg.sv
package pwpe_pkg;

   // Per-phase record carried from the forwarding point to the report point.
   typedef struct packed {
      logic vld;   // a forwarded data phase occupies this slot
      logic bad;   // its parity error was found on the initiator side and passed on
   } pwpe_tag_t;

   localparam int unsigned STS_INI_PED = 0;
   localparam int unsigned STS_TGT_DPD = 1;
   localparam int unsigned STS_SSE     = 2;
   localparam int unsigned STS_NUM     = 3;

endpackage

// File: rtl/pwpe_parity.sv
module pwpe_parity #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned BE_W  = DATA_W / 8
) (
   input  logic [DATA_W-1:0] ad,
   input  logic [BE_W-1:0]   cbe_n,
   output logic              par
);

   logic [BE_W-1:0] lane_par;

   // One xor tree per byte lane, folded together afterwards.
   for (genvar g = 0; g < BE_W; g++) begin : g_lane
      assign lane_par[g] = ^{ad[g*8 +: 8], cbe_n[g]};
   end

   assign par = ^lane_par;

endmodule

// File: rtl/pwpe_ini_side.sv
module pwpe_ini_side #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned BE_W  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              per_en,
   input  logic              xfer,
   input  logic [DATA_W-1:0] ad,
   input  logic [BE_W-1:0]   cbe_n,
   input  logic              par_in,
   output logic              perr_n,
   output logic              err,
   output logic              fwd_xfer,
   output logic [DATA_W-1:0] fwd_ad,
   output logic [BE_W-1:0]   fwd_cbe_n,
   output logic              fwd_par
);

   logic gen_par;

   // Parity is formed on the forwarded copy, which still holds the phase
   // whose parity bit arrives now.
   pwpe_parity #(.DATA_W(DATA_W)) u_par (
      .ad    (fwd_ad),
      .cbe_n (fwd_cbe_n),
      .par   (gen_par)
   );

   assign err = fwd_xfer && (gen_par != par_in);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_xfer  <= 1'b0;
         fwd_ad    <= '0;
         fwd_cbe_n <= '0;
      end else begin
         fwd_xfer <= xfer;
         if (xfer) begin
            fwd_ad    <= ad;
            fwd_cbe_n <= cbe_n;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         perr_n  <= 1'b1;
         fwd_par <= 1'b0;
      end else begin
         perr_n  <= !(err && per_en);
         fwd_par <= gen_par ^ err;
      end
   end

   // R1: a pulse only follows a phase two edges back, under the enable
   assert_perr_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n |-> ($past(xfer, 2) && $past(per_en)));

   // R4: forwarded word equals the accepted word, one clock later
   assert_fwd_intact_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_xfer |-> ($past(xfer) && fwd_ad == $past(ad) && fwd_cbe_n == $past(cbe_n)));

   // R3: the outgoing parity reproduces exactly what was received
   assert_fwd_par_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fwd_xfer) |-> (fwd_par == $past(par_in)));

endmodule

// File: rtl/pwpe_tag_pipe.sv
module pwpe_tag_pipe
   import pwpe_pkg::*;
#(
   parameter int unsigned DEPTH = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pwpe_tag_t tag_in,
   output pwpe_tag_t tag_out
);

   pwpe_tag_t stage [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= tag_in;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= stage[g-1];
         end
      end
   end

   assign tag_out = stage[DEPTH-1];

endmodule

// File: rtl/pwpe_tgt_side.sv
module pwpe_tgt_side
   import pwpe_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  pwpe_tag_t tag,
   input  logic      perr_in_n,
   input  logic      tgt_per_en,
   input  logic      ini_per_en,
   input  logic      serr_en,
   input  logic      serr_dis,
   output logic      dpd_set,
   output logic      serr_n
);

   logic report;
   logic gates_open;

   assign report     = !perr_in_n && tag.vld;
   assign gates_open = serr_en && !serr_dis && tgt_per_en && ini_per_en;
   assign dpd_set    = report && tgt_per_en;

   always_ff @(posedge clk) begin
      if (!rst_n) serr_n <= 1'b1;
      else        serr_n <= !(report && gates_open && !tag.bad);
   end

   // R7: no pulse for an error the bridge forwarded itself
   assert_no_serr_forwarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n |-> !$past(tag.bad));

   // R8: a pulse needs a low report on a slot holding a phase
   assert_serr_needs_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n |-> ($past(tag.vld) && !$past(perr_in_n)));

   // R6: one low clock for each report
   assert_serr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!serr_n && !$past(report)) |=> serr_n);

endmodule

// File: rtl/pwpe_status.sv
module pwpe_status #(
   parameter int unsigned NUM = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] set,
   input  logic [NUM-1:0] clr,
   output logic [NUM-1:0] q
);

   for (genvar g = 0; g < NUM; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)      q[g] <= 1'b0;
         else if (set[g]) q[g] <= 1'b1;
         else if (clr[g]) q[g] <= 1'b0;
      end

      // R9: set wins, and a bare clear empties the bit
      assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $past(set[g]) |-> q[g]);
      assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $past(clr[g] && !set[g]) |-> !q[g]);
   end

endmodule

// File: rtl/pwpe_handler.sv
module pwpe_handler
   import pwpe_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned TGT_PERR_LAT = 3,
   localparam int unsigned BE_W        = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ini_per_en,
   input  logic              tgt_per_en,
   input  logic              serr_en,
   input  logic              pw_serr_dis,
   input  logic              ini_xfer,
   input  logic [DATA_W-1:0] ini_ad,
   input  logic [BE_W-1:0]   ini_cbe_n,
   input  logic              ini_par,
   output logic              ini_perr_n,
   output logic              tgt_xfer,
   output logic [DATA_W-1:0] tgt_ad,
   output logic [BE_W-1:0]   tgt_cbe_n,
   output logic              tgt_par,
   input  logic              tgt_perr_n,
   output logic              ini_serr_n,
   output logic              sts_ini_ped,
   output logic              sts_tgt_dpd,
   output logic              sts_sse,
   input  logic              clr_ini_ped,
   input  logic              clr_tgt_dpd,
   input  logic              clr_sse
);

   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_chk_dw
      $error("pwpe_handler: DATA_W must be a nonzero multiple of 8");
   end
   if (TGT_PERR_LAT < 1 || TGT_PERR_LAT > 16) begin : g_chk_lat
      $error("pwpe_handler: TGT_PERR_LAT must lie in 1..16");
   end

   logic          ini_err;
   logic          dpd_set;
   pwpe_tag_t     tag_head;
   pwpe_tag_t     tag_due;
   logic [STS_NUM-1:0] sts_set;
   logic [STS_NUM-1:0] sts_clr;
   logic [STS_NUM-1:0] sts_q;

   pwpe_ini_side #(.DATA_W(DATA_W)) u_ini (
      .clk       (clk),
      .rst_n     (rst_n),
      .per_en    (ini_per_en),
      .xfer      (ini_xfer),
      .ad        (ini_ad),
      .cbe_n     (ini_cbe_n),
      .par_in    (ini_par),
      .perr_n    (ini_perr_n),
      .err       (ini_err),
      .fwd_xfer  (tgt_xfer),
      .fwd_ad    (tgt_ad),
      .fwd_cbe_n (tgt_cbe_n),
      .fwd_par   (tgt_par)
   );

   // The target samples the forwarded phase at the same edge the tag enters.
   assign tag_head.vld = tgt_xfer;
   assign tag_head.bad = ini_err;

   pwpe_tag_pipe #(.DEPTH(TGT_PERR_LAT)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .tag_in  (tag_head),
      .tag_out (tag_due)
   );

   pwpe_tgt_side u_tgt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tag        (tag_due),
      .perr_in_n  (tgt_perr_n),
      .tgt_per_en (tgt_per_en),
      .ini_per_en (ini_per_en),
      .serr_en    (serr_en),
      .serr_dis   (pw_serr_dis),
      .dpd_set    (dpd_set),
      .serr_n     (ini_serr_n)
   );

   // The signalled-error bit rides the same edge as the pulse it records.
   always_comb begin
      sts_set              = '0;
      sts_set[STS_INI_PED] = ini_err;
      sts_set[STS_TGT_DPD] = dpd_set;
      sts_set[STS_SSE]     = 1'b0;
      sts_clr              = '0;
      sts_clr[STS_INI_PED] = clr_ini_ped;
      sts_clr[STS_TGT_DPD] = clr_tgt_dpd;
      sts_clr[STS_SSE]     = clr_sse;
   end

   logic sse_q;

   pwpe_status #(.NUM(STS_NUM - 1)) u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (sts_set[STS_TGT_DPD:STS_INI_PED]),
      .clr   (sts_clr[STS_TGT_DPD:STS_INI_PED]),
      .q     (sts_q[STS_TGT_DPD:STS_INI_PED])
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                                              sse_q <= 1'b0;
      else if (!tgt_perr_n && tag_due.vld && !tag_due.bad &&
               serr_en && !pw_serr_dis && tgt_per_en && ini_per_en) sse_q <= 1'b1;
      else if (clr_sse)                                        sse_q <= 1'b0;
   end
   assign sts_q[STS_SSE] = sse_q;

   assign sts_ini_ped = sts_q[STS_INI_PED];
   assign sts_tgt_dpd = sts_q[STS_TGT_DPD];
   assign sts_sse     = sts_q[STS_SSE];

   // R6: a system-error pulse is always recorded in its status bit
   assert_serr_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ini_serr_n |-> sts_sse);

   // R2: an initiator parity pulse always comes with its status bit
   assert_perr_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ini_perr_n && !$past(clr_ini_ped)) |-> sts_ini_ped);

endmodule

// File: tb/pwpe_handler_tb.sv
module pwpe_handler_tb;

   localparam int DW      = 32;
   localparam int BW      = DW / 8;
   localparam int LAT     = 3;
   localparam int CLK_PER = 10;
   localparam int WDOG    = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ini_per_en = 1'b0, tgt_per_en = 1'b0, serr_en = 1'b0, pw_serr_dis = 1'b0;
   logic          ini_xfer = 1'b0;
   logic [DW-1:0] ini_ad = '0;
   logic [BW-1:0] ini_cbe_n = '0;
   logic          ini_par = 1'b0;
   logic          tgt_perr_n = 1'b1;
   logic          clr_ini_ped = 1'b0, clr_tgt_dpd = 1'b0, clr_sse = 1'b0;
   logic          ini_perr_n, tgt_xfer, tgt_par, ini_serr_n;
   logic [DW-1:0] tgt_ad;
   logic [BW-1:0] tgt_cbe_n;
   logic          sts_ini_ped, sts_tgt_dpd, sts_sse;

   int checks = 0;
   int errors = 0;

   always #(CLK_PER/2) clk = ~clk;

   pwpe_handler #(.DATA_W(DW), .TGT_PERR_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ini_per_en(ini_per_en), .tgt_per_en(tgt_per_en),
      .serr_en(serr_en), .pw_serr_dis(pw_serr_dis),
      .ini_xfer(ini_xfer), .ini_ad(ini_ad), .ini_cbe_n(ini_cbe_n), .ini_par(ini_par),
      .ini_perr_n(ini_perr_n),
      .tgt_xfer(tgt_xfer), .tgt_ad(tgt_ad), .tgt_cbe_n(tgt_cbe_n), .tgt_par(tgt_par),
      .tgt_perr_n(tgt_perr_n), .ini_serr_n(ini_serr_n),
      .sts_ini_ped(sts_ini_ped), .sts_tgt_dpd(sts_tgt_dpd), .sts_sse(sts_sse),
      .clr_ini_ped(clr_ini_ped), .clr_tgt_dpd(clr_tgt_dpd), .clr_sse(clr_sse)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- emulated target: answers LAT edges after sampling a phase
   logic inj_now = 1'b0, inj_d, t_pend, t_calc, t_inj, sh0, sh1;
   always @(posedge clk) begin
      if (!rst_n) begin
         inj_d <= 1'b0; t_pend <= 1'b0; t_calc <= 1'b0; t_inj <= 1'b0;
         sh0 <= 1'b0; sh1 <= 1'b0;
      end else begin
         inj_d  <= inj_now;
         t_pend <= tgt_xfer;
         t_calc <= ^{tgt_ad, tgt_cbe_n};
         t_inj  <= inj_d;
         sh0    <= t_pend && ((tgt_par != t_calc) || t_inj);
         sh1    <= sh0;
      end
   end

   // ---------------- behavioural reference model
   int            cyc;
   bit            tagv [8];
   bit            tagb [8];
   bit            m_perr_n, m_serr_n, m_ped, m_dpd, m_sse, m_txfer, m_tpar, tpar_chk;
   bit [DW-1:0]   m_tad;
   bit [BW-1:0]   m_tcbe;
   int            perr_tot = 0, serr_tot = 0;

   always @(posedge clk) begin
      bit evt, bad, err, gpar;
      int rd;
      if (!rst_n) begin
         cyc = 0;
         foreach (tagv[i]) begin tagv[i] = 0; tagb[i] = 0; end
         m_perr_n = 1; m_serr_n = 1; m_ped = 0; m_dpd = 0; m_sse = 0;
         m_txfer = 0; m_tpar = 0; tpar_chk = 0; m_tad = '0; m_tcbe = '0;
      end else begin
         cyc++;
         rd   = (cyc + 8 - LAT) % 8;
         evt  = !tgt_perr_n && tagv[rd];
         bad  = tagb[rd];
         gpar = ^{m_tad, m_tcbe};
         err  = m_txfer && (gpar != ini_par);
         tagv[cyc % 8] = m_txfer;
         tagb[cyc % 8] = err;
         m_perr_n = !(err && ini_per_en);
         tpar_chk = m_txfer;
         if (m_txfer) m_tpar = gpar ^ err;
         m_serr_n = !(evt && serr_en && !pw_serr_dis && tgt_per_en && ini_per_en && !bad);
         m_ped = (m_ped && !clr_ini_ped) || err;
         m_dpd = (m_dpd && !clr_tgt_dpd) || (evt && tgt_per_en);
         m_sse = (m_sse && !clr_sse) || !m_serr_n;
         m_txfer = ini_xfer;
         if (ini_xfer) begin m_tad = ini_ad; m_tcbe = ini_cbe_n; end
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1", "ini_perr_n", ini_perr_n, m_perr_n);
         chk("R2", "sts_ini_ped", sts_ini_ped, m_ped);
         chk("R4", "tgt_xfer", tgt_xfer, m_txfer);
         chk("R4", "tgt_ad", tgt_ad, m_tad);
         chk("R4", "tgt_cbe_n", tgt_cbe_n, m_tcbe);
         if (tpar_chk) chk("R3", "tgt_par", tgt_par, m_tpar);
         chk("R5", "sts_tgt_dpd", sts_tgt_dpd, m_dpd);
         chk("R6", "ini_serr_n", ini_serr_n, m_serr_n);
         chk("R9", "sts_sse", sts_sse, m_sse);
         if (!ini_perr_n) perr_tot++;
         if (!ini_serr_n) serr_tot++;
      end
   end

   // ---------------- stimulus
   logic nxt_par = 1'b0;

   task automatic step(input logic xfer = 0, input logic [DW-1:0] ad = '0,
                       input logic [BW-1:0] cbe = '0, input logic corrupt = 0,
                       input logic inject = 0, input logic spur = 0,
                       input logic [2:0] clr = 3'b000);
      @(negedge clk);
      ini_par     = nxt_par;
      nxt_par     = xfer ? ((^{ad, cbe}) ^ corrupt) : 1'b0;
      ini_xfer    = xfer;
      ini_ad      = ad;
      ini_cbe_n   = cbe;
      inj_now     = xfer & inject;
      tgt_perr_n  = !(sh1 | spur);
      clr_ini_ped = clr[0];
      clr_tgt_dpd = clr[1];
      clr_sse     = clr[2];
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic enables(input logic ipe, input logic tpe, input logic se, input logic dis);
      ini_per_en = ipe; tgt_per_en = tpe; serr_en = se; pw_serr_dis = dis;
   endtask

   int p0, s0;

   initial begin : watchdog
      repeat (WDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(4);
      chk("R4", "reset tgt_xfer", tgt_xfer, 0);
      chk("R1", "reset ini_perr_n", ini_perr_n, 1);
      chk("R6", "reset ini_serr_n", ini_serr_n, 1);
      chk("R9", "reset status", {sts_ini_ped, sts_tgt_dpd, sts_sse}, 0);
      rst_n = 1'b1;
      enables(1, 1, 1, 0);

      // clean back-to-back writes with varied patterns
      step(1, 32'h0000_0000, 4'h0);
      step(1, 32'hFFFF_FFFF, 4'hF);
      step(1, 32'hA5A5_5A5A, 4'h3);
      step(1, 32'h1234_5678, 4'h8);
      step(1, 32'h8000_0001, 4'h1);
      idle(8);
      chk("R2", "clean writes leave ped clear", sts_ini_ped, 0);
      chk("R6", "clean writes no serr", sts_sse, 0);

      // initiator-side error, forwarded, target reports it
      p0 = perr_tot; s0 = serr_tot;
      step(1, 32'hDEAD_BEEF, 4'h0, 1);
      idle(8);
      chk("R1", "perr pulse count", perr_tot - p0, 1);
      chk("R2", "ped set", sts_ini_ped, 1);
      chk("R5", "dpd set on forwarded error", sts_tgt_dpd, 1);
      chk("R7", "no serr for forwarded error", serr_tot - s0, 0);
      chk("R7", "sse clear for forwarded error", sts_sse, 0);
      step(.clr(3'b111));
      idle(1);
      chk("R9", "w1c clears all", {sts_ini_ped, sts_tgt_dpd, sts_sse}, 0);

      // response enable off: no pulse, status still set
      enables(0, 1, 1, 0);
      p0 = perr_tot;
      step(1, 32'h0F0F_0F0F, 4'h5, 1);
      idle(8);
      chk("R1", "no perr when disabled", perr_tot - p0, 0);
      chk("R2", "ped set regardless of enable", sts_ini_ped, 1);
      step(.clr(3'b111));
      enables(1, 1, 1, 0);

      // target-side corruption of a clean phase -> system error
      s0 = serr_tot;
      step(1, 32'hCAFE_F00D, 4'h2, 0, 1);
      idle(8);
      chk("R6", "one serr pulse", serr_tot - s0, 1);
      chk("R6", "sse set", sts_sse, 1);
      chk("R5", "dpd set", sts_tgt_dpd, 1);
      chk("R2", "ped untouched by target error", sts_ini_ped, 0);

      // each gate closed in turn
      for (int g = 0; g < 4; g++) begin
         step(.clr(3'b111));
         enables(g != 3, g != 2, g != 0, g == 1);
         s0 = serr_tot;
         step(1, 32'h1111_0000 + g, 4'h4, 0, 1);
         idle(8);
         chk("R6", "gate closed no serr", serr_tot - s0, 0);
         chk("R6", "gate closed sse clear", sts_sse, 0);
         chk("R5", "dpd follows tgt_per_en", sts_tgt_dpd, (g != 2));
      end
      step(.clr(3'b111));
      enables(1, 1, 1, 0);

      // report with no phase due
      s0 = serr_tot;
      idle(4);
      step(.spur(1));
      idle(6);
      chk("R8", "spurious report no serr", serr_tot - s0, 0);
      chk("R8", "spurious report no dpd", sts_tgt_dpd, 0);

      // set wins over a simultaneous clear
      step(1, 32'h7777_7777, 4'h0, 1);
      step(.clr(3'b001));
      idle(1);
      chk("R9", "set beats clear", sts_ini_ped, 1);
      idle(8);
      step(.clr(3'b111));

      // back-to-back: forwarded-bad next to target-corrupted clean phase
      s0 = serr_tot;
      step(1, 32'h0000_00FF, 4'h1, 0, 0);
      step(1, 32'h0000_FF00, 4'h2, 1, 0);
      step(1, 32'h00FF_0000, 4'h4, 0, 1);
      step(1, 32'hFF00_0000, 4'h8, 1, 1);
      idle(10);
      chk("R7", "only the clean corrupted phase signals", serr_tot - s0, 1);
      chk("R6", "sse after mixed burst", sts_sse, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule